// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a register-mapped watchdog for an SoC peripheral bus. A free-running prescaler divides the core clock by 32. A tick counter then counts up to a terminal count that software picks as a power of two. When the terminal count is reached, the block sends a single-cycle reset request to the system reset logic. It also latches a sticky cause flag in a status register and starts counting again from zero.

Software keeps the system alive by writing a fixed 16-bit service key into the upper half-word of the control word. Any other value written there, or the same value written with the wrong byte lanes, does not service the timer. An optional window mode treats a service that comes too early as a fault. Each register also has a set alias and a clear alias, so single bits can be changed without a read-modify-write. Right after the timer is switched off there is a one-cycle blackout, during which the register file ignores all accesses.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word (0x00) and the status word (0x10) both read 0 and `rstReq` is low.
- R2: Control word fields: bit 15 run enable, bits 12:8 scale exponent `ps`, bits 7:6 a clock-select code that is stored but has no effect on counting, bit 0 window enable. All other bits read 0. A write at 0x00 updates only the byte lanes whose `busBe` bit is 1.
- R3: A write to 0x04 sets the control bits where the write data has a 1. A write to 0x08 clears them. Bits written as 0 are left unchanged, and byte enables apply to both aliases.
- R4: Setting the run bit starts the prescaler and the tick counter from zero. `rstReq` is high for exactly the one cycle that follows the 32*2^ps-th clock edge after the enabling write. Counting then restarts, so the pulses repeat with that period.
- R5: Every timeout sets status bit 4. Bit 4 stays set until a write to 0x18 with data bit 4 = 1 and `busBe[0]` = 1. Writes to 0x10 or 0x14, and writes to 0x18 with data bit 4 = 0, leave it set. Status bits 2 and 3 read 0.
- R6: A write at 0x00 with `busBe` = 4'b1100 and `busWdata[31:16]` = 16'h5743 clears the prescaler and the tick counter on that edge. The next timeout is then 32*2^ps edges later. A different value, or any other byte-enable pattern, does not service the timer.
- R7: While the run bit is 0 the counters stay at zero and `rstReq` never rises.
- R8: During the cycle that immediately follows the clearing of the run bit, writes are ignored and reads return 0.
- R9: With the window bit set and ps > 0, a valid key written while the tick count is below 2^(ps-1) causes a timeout at once: `rstReq` is high in the cycle after that write, and counting restarts.
- R10: A valid key whose write edge coincides with the terminal-count edge wins. No pulse is raised and no flag is set, and the next timeout comes a full period after the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register access |
| busWr | input | 1 | Write strobe, valid for one cycle per access |
| busBe | input | 4 | Byte-lane enables for the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| rstReq | output | 1 | One-cycle reset request on a timeout |

## Verification
The timer is run with ps = 0 and ps = 2. This separates a comparison against the count itself from one against the terminal value, and the pulse edges are checked to the exact cycle on both sides. Keys are written in three places: in the middle of a period, on the terminal edge, and inside the early window. This distinguishes a service that restarts the count from one that is ignored, loses to the timeout, or faults. Wrong key values and wrong byte lanes show whether key detection is exact. Writes made just after switch-off, and alias writes with mixed 0 and 1 bits, show whether the lane and alias masks are applied correctly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W   = 5;
  localparam int PS_W     = 5;
  localparam int CS_W     = 2;
  localparam int ON_BIT   = 15;
  localparam int PS_LSB   = 8;
  localparam int CS_LSB   = 6;
  localparam int WIN_BIT  = 0;
  localparam int FLAG_BIT = 4;
  localparam logic [15:0] SERVICE_KEY = 16'h5743;

  localparam logic [31:0] CTRL_MASK =
      (32'd1 << ON_BIT) | (32'((1 << PS_W) - 1) << PS_LSB) |
      (32'((1 << CS_W) - 1) << CS_LSB) | (32'd1 << WIN_BIT);

  localparam logic [ADDR_W-1:0] A_CTRL     = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 5'h08;
  localparam logic [ADDR_W-1:0] A_STAT     = 5'h10;
  localparam logic [ADDR_W-1:0] A_STAT_SET = 5'h14;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 5'h18;

  typedef struct packed {
    logic            run;
    logic            window;
    logic            kick;
    logic [PS_W-1:0] ps;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  input  logic              toEvent,
  output wdtStrobe_t        strobe,
  output logic [31:0]       busRdata
);
  logic [31:0] ctrlQ, ctrlD, laneMask, maskedData;
  logic        flagQ, prevOn, blackout, wrOk, flagClr;

  assign blackout = prevOn & ~ctrlQ[ON_BIT];
  assign wrOk     = busWr & ~blackout;

  always_comb begin
    for (int i = 0; i < 4; i++) laneMask[8*i +: 8] = {8{busBe[i]}};
  end
  assign maskedData = busWdata & laneMask;

  always_comb begin
    ctrlD = ctrlQ;
    if (wrOk) begin
      case (busAddr)
        A_CTRL:     ctrlD = (ctrlQ & ~laneMask) | maskedData;
        A_CTRL_SET: ctrlD = ctrlQ | maskedData;
        A_CTRL_CLR: ctrlD = ctrlQ & ~maskedData;
        default:    ctrlD = ctrlQ;
      endcase
    end
    ctrlD = ctrlD & CTRL_MASK;
  end

  assign flagClr = wrOk && (busAddr == A_STAT_CLR) && maskedData[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      flagQ  <= 1'b0;
      prevOn <= 1'b0;
    end else begin
      ctrlQ  <= ctrlD;
      prevOn <= ctrlQ[ON_BIT];
      if (toEvent)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  assign strobe.run    = ctrlQ[ON_BIT];
  assign strobe.window = ctrlQ[WIN_BIT];
  assign strobe.ps     = ctrlQ[PS_LSB +: PS_W];
  assign strobe.kick   = wrOk && (busAddr == A_CTRL) && (busBe == 4'b1100) &&
                         (busWdata[31:16] == SERVICE_KEY);

  always_comb begin
    busRdata = '0;
    if (!blackout) begin
      case (busAddr)
        A_CTRL, A_CTRL_SET, A_CTRL_CLR: busRdata = ctrlQ;
        A_STAT, A_STAT_SET, A_STAT_CLR: busRdata = 32'(flagQ) << FLAG_BIT;
        default:                        busRdata = '0;
      endcase
    end
  end

  // R8
  blackout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blackout && busWr) |=> $stable(ctrlQ));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(busWr && busAddr == A_STAT_CLR && busBe[0] && busWdata[FLAG_BIT]))
      |=> flagQ);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int PRE_DIV = 32,
  parameter int CNT_W   = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobe,
  output logic       toEvent,
  output logic       rstReq
);
  localparam int PRE_W = $clog2(PRE_DIV);

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ, tcVal;
  logic             tick, early, violate, expire, rstReqQ;

  assign tick    = (preQ == PRE_W'(PRE_DIV - 1));
  assign tcVal   = ~({CNT_W{1'b1}} << strobe.ps);
  assign early   = (strobe.ps != '0) && (cntQ <= (tcVal >> 1));
  assign violate = strobe.run & strobe.kick & strobe.window & early;
  assign expire  = strobe.run & tick & (cntQ >= tcVal) & ~strobe.kick;
  assign toEvent = violate | expire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ    <= '0;
      cntQ    <= '0;
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= toEvent;
      if (!strobe.run || strobe.kick || toEvent) begin
        preQ <= '0;
        cntQ <= '0;
      end else begin
        preQ <= tick ? '0 : preQ + 1'b1;
        if (tick) cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign rstReq = rstReqQ;

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (cntQ == '0 && preQ == '0 && !rstReqQ));

  // R10
  key_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && strobe.kick && !strobe.window) |=> !rstReqQ);

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |-> ($past(strobe.kick) || $past(preQ) == PRE_W'(PRE_DIV - 1)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int PRE_DIV = 32,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq
);
  wdtStrobe_t strobe;
  logic       toEvent;

  wdt_regs u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busBe(busBe),
    .busWdata(busWdata), .toEvent(toEvent), .strobe(strobe), .busRdata(busRdata)
  );

  wdt_count #(.PRE_DIV(PRE_DIV), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .toEvent(toEvent), .rstReq(rstReq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !rstReq);
endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;
  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the negedge after it
  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be);
    busAddr = a; busWdata = d; busBe = be; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busBe = '0; busWdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countPulses(int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstReq) p++;
    end
  endtask

  task automatic stopAll();
    wr(5'h08, 32'h0000_8000, 4'b0011);
    idle(1);
    wr(5'h00, 32'h0, 4'b1111);
    wr(5'h18, 32'h10, 4'b0001);
  endtask

  task automatic tReset();
    logic [31:0] d;
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h10, d); chk("R1 status", d, 0);
    chk("R1 rstReq", rstReq, 0);
  endtask

  task automatic tFields();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFFF, 4'b1111);
    rd(5'h00, d); chk("R2 field mask", d, 32'h0000_9FC1);
    wr(5'h00, 32'h0, 4'b0001);
    rd(5'h00, d); chk("R2 byte lane", d, 32'h0000_9F00);
    stopAll();
    rd(5'h00, d); chk("R2 cleared", d, 0);
  endtask

  task automatic tAlias();
    logic [31:0] d;
    wr(5'h04, 32'h0000_0041, 4'b0001);
    rd(5'h00, d); chk("R3 set alias", d, 32'h41);
    wr(5'h08, 32'h0000_0001, 4'b0001);
    rd(5'h00, d); chk("R3 clr alias", d, 32'h40);
    wr(5'h04, 32'h0000_03FF, 4'b0010);
    rd(5'h00, d); chk("R3 set alias lanes", d, 32'h340);
    wr(5'h08, 32'h0000_FFFF, 4'b0011);
    rd(5'h04, d); chk("R3 clr all", d, 0);
  endtask

  task automatic tTimeout();
    int p;
    logic [31:0] d;
    wr(5'h00, 32'h0000_80C0, 4'b0011);
    countPulses(31, p); chk("R4 before first period", p, 0);
    idle(1); chk("R4 pulse at 32", rstReq, 1);
    idle(1); chk("R4 one cycle", rstReq, 0);
    countPulses(30, p); chk("R4 gap", p, 0);
    idle(1); chk("R4 periodic pulse", rstReq, 1);
    rd(5'h10, d); chk("R5 flag set", d, 32'h10);
    stopAll();
  endtask

  task automatic tFlag();
    logic [31:0] d;
    wr(5'h00, 32'h0000_8000, 4'b0011);
    idle(40);
    wr(5'h08, 32'h0000_8000, 4'b0011);
    idle(1);
    wr(5'h10, 32'h0, 4'b1111);
    wr(5'h14, 32'hFFFF_FFFF, 4'b1111);
    wr(5'h18, 32'hFFFF_FFEF, 4'b1111);
    rd(5'h10, d); chk("R5 sticky", d, 32'h10);
    wr(5'h18, 32'h10, 4'b0001);
    rd(5'h18, d); chk("R5 clear", d, 0);
  endtask

  task automatic tKey();
    int p;
    wr(5'h00, 32'h0000_8200, 4'b0011);
    idle(99);
    wr(5'h00, 32'h5743_0000, 4'b1100);
    countPulses(127, p); chk("R6 key restarts count", p, 0);
    idle(1); chk("R6 pulse after key", rstReq, 1);
    wr(5'h00, 32'h5744_0000, 4'b1100);
    wr(5'h00, 32'h5743_0000, 4'b0100);
    countPulses(125, p); chk("R6 bad key quiet", p, 0);
    idle(1); chk("R6 bad key no service", rstReq, 1);
    stopAll();
  endtask

  task automatic tOff();
    int p;
    wr(5'h00, 32'h0000_0000, 4'b0011);
    wr(5'h00, 32'h5743_0000, 4'b1100);
    countPulses(200, p); chk("R7 off no pulse", p, 0);
  endtask

  task automatic tBlackout();
    logic [31:0] d;
    wr(5'h00, 32'h0000_8500, 4'b0011);
    wr(5'h08, 32'h0000_8000, 4'b0011);
    rd(5'h00, d); chk("R8 read zero", d, 0);
    wr(5'h00, 32'h0000_1F00, 4'b0011);
    rd(5'h00, d); chk("R8 write ignored", d, 32'h0500);
    stopAll();
  endtask

  task automatic tWindow();
    int p;
    wr(5'h00, 32'h0000_8201, 4'b0011);
    wr(5'h00, 32'h5743_0000, 4'b1100);
    chk("R9 early key faults", rstReq, 1);
    idle(68);
    wr(5'h00, 32'h5743_0000, 4'b1100);
    countPulses(127, p); chk("R9 late key ok", p, 0);
    idle(1); chk("R9 next timeout", rstReq, 1);
    stopAll();
  endtask

  task automatic tKeyAtTc();
    int p;
    logic [31:0] d;
    wr(5'h00, 32'h0000_8000, 4'b0011);
    idle(31);
    wr(5'h00, 32'h5743_0000, 4'b1100);
    chk("R10 no pulse", rstReq, 0);
    rd(5'h10, d); chk("R10 no flag", d, 0);
    countPulses(31, p); chk("R10 quiet", p, 0);
    idle(1); chk("R10 full period", rstReq, 1);
    stopAll();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tFields();
    tAlias();
    tTimeout();
    tFlag();
    tKey();
    tOff();
    tBlackout();
    tWindow();
    tKeyAtTc();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule